// File: doc/BRIEF.md
# Byte-wide SPI master shift engine

This block is the master side of a serial peripheral link, moving one byte per transfer. A processor-side write of a byte is the only way to start a transfer. The engine then shifts that byte out on SDO, most significant bit first, while it collects the same number of bits from SDI. When the eighth bit is in, the received byte is placed in a read buffer, a buffer-full status is raised and a one-cycle interrupt pulse is sent.

Four configuration inputs shape the serial timing. `cpol` gives the level at which SCK rests. `cpha` selects whether SCK is active in the first or the second half of each bit. `smp_late` selects whether SDI is captured in the middle or at the end of a bit. `rate_sel` picks the bit clock. It can be one of three fixed divisions of the system clock, or an external timer tick divided by two. With `sdo_en` low the engine still clocks and receives while SDO stays low, so it can act as a receive-only line monitor.

A write made during a transfer is dropped and latches a collision flag. A byte that finishes while the buffer still holds an unread byte is discarded and latches an overrun flag.

Top module: `spi_shift_master`

## Requirements
- R1: A `wr_en` pulse while idle starts a transfer that lasts exactly 16 half-bit periods. `xfer_irq` is high for exactly one cycle, in the cycle that follows the clock edge ending the 16th half-bit period.
- R2: Data leaves on SDO most significant bit first. Bit 7-k is driven during half-bit periods 2k and 2k+1, for k = 0..7.
- R3: Whenever no transfer runs, SCK equals `cpol`: low for 0, high for 1.
- R4: During a transfer, with `cpha`=0 SCK is at the active level (not `cpol`) in the even half-bit periods, so its first edge coincides with each data change. With `cpha`=1 SCK is active in the odd half-bit periods, so data is valid before the first edge.
- R5: With `smp_late`=0, SDI is captured at the end of half-bit period 2k (mid-bit). With `smp_late`=1 it is captured at the end of period 2k+1 (end of bit). Captured bits fill the byte from bit 7 down to bit 0.
- R6: `rate_sel` codes 0, 1 and 2 give half-bit periods of 2, 8 and 32 system clocks (bit rate = clock/4, /16, /64). Code 3 makes each `tmr_tick` pulse end one half-bit period (bit rate = tick rate / 2).
- R7: At completion, the received byte appears on `rd_data` and `buf_full` rises in the same cycle as `xfer_irq`.
- R8: With `sdo_en`=0, SDO stays low for the whole transfer, and the received byte is still delivered to the buffer as in R7.
- R9: A `wr_en` pulse during a transfer neither changes the data being sent nor starts a new transfer. It sets `wcol_flag`, which stays set.
- R10: A byte that completes while `buf_full` is set does not replace `rd_data`. It sets `ovf_flag`, which stays set. A `rd_en` pulse clears `buf_full`.
- R11: While `rst_n` is low, SCK equals `cpol` and SDO, `buf_full`, `xfer_irq`, `ovf_flag`, `wcol_flag` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the transmit byte; starts a transfer when idle |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe; clears buffer-full |
| rd_data | output | 8 | Last byte accepted into the read buffer |
| buf_full | output | 1 | Read buffer holds an unread byte |
| xfer_irq | output | 1 | One-cycle transfer-complete pulse |
| ovf_flag | output | 1 | Sticky: a byte was lost because the buffer was full |
| wcol_flag | output | 1 | Sticky: a write arrived during a transfer |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: SCK active in first half of each bit; 1: in second half |
| smp_late | input | 1 | 0: sample SDI mid-bit; 1: sample at end of bit |
| rate_sel | input | 2 | Bit clock source: 0 clk/4, 1 clk/16, 2 clk/64, 3 timer tick/2 |
| tmr_tick | input | 1 | External timer tick used when `rate_sel` is 3 |
| sdo_en | input | 1 | SDO output enable; low gives receive-only operation |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The assertions check the following on every cycle:
- SCK rests at `cpol` whenever the engine is idle.
- Each transfer ends only after its last half-bit period.
- The interrupt never lasts more than one cycle.
- Completion raises buffer-full.
- A full buffer keeps its contents.
- Both sticky flags stay set once raised.
- A colliding write never cuts a transfer short.

Only the directed scenarios can show:
- The bit order on SDO.
- The SCK waveform for each polarity and phase.
- Which SDI value the two sample points take.
- The exact transfer length for each rate source.
- Receive-only operation.

These checks need a bench that drives different SDI values in the two halves of each bit and compares the serial pins against bytes it computed beforehand.

// File: rtl/spi_shift_master_pkg.sv
package spi_shift_master_pkg;

  typedef enum logic [1:0] {
    RATE_DIV_LO  = 2'd0,
    RATE_DIV_MID = 2'd1,
    RATE_DIV_HI  = 2'd2,
    RATE_TICK    = 2'd3
  } rate_e;

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_shift_master_pkg::*;
#(
  parameter int DIV_LO  = 4,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_e rate,
  input  logic  tmr_tick,
  output logic  hstep
);

  localparam int HALF_LO  = DIV_LO / 2;
  localparam int HALF_MID = DIV_MID / 2;
  localparam int HALF_HI  = DIV_HI / 2;
  localparam int CW       = $clog2(HALF_HI + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim_m1;
  logic          hit;

  always_comb begin
    case (rate)
      RATE_DIV_LO:  lim_m1 = CW'(HALF_LO - 1);
      RATE_DIV_MID: lim_m1 = CW'(HALF_MID - 1);
      default:      lim_m1 = CW'(HALF_HI - 1);
    endcase
  end

  assign hit = (cnt_q == lim_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || rate == RATE_TICK) begin
      cnt_d = '0;
    end else if (hit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign hstep = run & ((rate == RATE_TICK) ? tmr_tick : hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx_data,
  input  logic         hstep,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         smp_late,
  input  logic         sdo_en,
  input  logic         sdi,
  output logic         busy,
  output logic         sck,
  output logic         sdo,
  output logic         done,
  output logic [W-1:0] rx_word
);

  localparam int HC = 2 * W;
  localparam int HW = $clog2(HC);

  logic          busy_q, busy_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [W-1:0]  sh_q, sh_d;
  logic          mid_q, mid_d;
  logic          last_half, second_half, in_bit;

  assign last_half   = (hcnt_q == HW'(HC - 1));
  assign second_half = hcnt_q[0];
  assign in_bit      = smp_late ? sdi : mid_q;

  always_comb begin
    busy_d = busy_q;
    hcnt_d = hcnt_q;
    sh_d   = sh_q;
    mid_d  = mid_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        hcnt_d = '0;
        sh_d   = tx_data;
      end
    end else if (hstep) begin
      if (!second_half) begin
        if (!smp_late) mid_d = sdi;
      end else begin
        sh_d = {sh_q[W-2:0], in_bit};
      end
      if (last_half) begin
        busy_d = 1'b0;
        hcnt_d = '0;
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hcnt_q <= '0;
      sh_q   <= '0;
      mid_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      hcnt_q <= hcnt_d;
      sh_q   <= sh_d;
      mid_q  <= mid_d;
    end
  end

  assign busy    = busy_q;
  assign done    = busy_q & hstep & last_half;
  assign rx_word = {sh_q[W-2:0], in_bit};
  assign sck     = busy_q ? (cpol ^ (cpha ? hcnt_q[0] : ~hcnt_q[0])) : cpol;
  assign sdo     = busy_q & sdo_en & sh_q[W-1];

  assert_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(hcnt_q) == HW'(HC - 1));

  assert_collision_keeps_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !done) |=> busy_q);

endmodule

// File: rtl/spi_rx_buffer.sv
module spi_rx_buffer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  logic [W-1:0] rx_word,
  input  logic         rd_en,
  input  logic         wcol_evt,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         irq,
  output logic         ovf,
  output logic         wcol
);

  logic [W-1:0] buf_q, buf_d;
  logic         full_q, full_d;
  logic         irq_q, irq_d;
  logic         ovf_q, ovf_d;
  logic         wcol_q, wcol_d;

  always_comb begin
    buf_d  = buf_q;
    full_d = full_q;
    ovf_d  = ovf_q;
    wcol_d = wcol_q | wcol_evt;
    irq_d  = done;
    if (rd_en) full_d = 1'b0;
    if (done) begin
      if (!full_q) begin
        buf_d  = rx_word;
        full_d = 1'b1;
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      full_q <= full_d;
      irq_q  <= irq_d;
      ovf_q  <= ovf_d;
      wcol_q <= wcol_d;
    end
  end

  assign rd_data = buf_q;
  assign full    = full_q;
  assign irq     = irq_q;
  assign ovf     = ovf_q;
  assign wcol    = wcol_q;

  assert_irq_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  assert_full_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rd_en) |=> full_q);

  assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(buf_q));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  assert_wcol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_q |=> wcol_q);

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_shift_master_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_LO  = 4,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic              xfer_irq,
  output logic              ovf_flag,
  output logic              wcol_flag,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              smp_late,
  input  logic [1:0]        rate_sel,
  input  logic              tmr_tick,
  input  logic              sdo_en,
  output logic              sck,
  output logic              sdo,
  input  logic              sdi
);

  logic              busy_w, hstep_w, done_w, wcol_evt;
  logic [DATA_W-1:0] rx_word_w;

  assign wcol_evt = wr_en & busy_w;

  spi_rate_gen #(
    .DIV_LO (DIV_LO),
    .DIV_MID(DIV_MID),
    .DIV_HI (DIV_HI)
  ) u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy_w),
    .rate    (rate_e'(rate_sel)),
    .tmr_tick(tmr_tick),
    .hstep   (hstep_w)
  );

  spi_shifter #(.W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (wr_en),
    .tx_data (wr_data),
    .hstep   (hstep_w),
    .cpol    (cpol),
    .cpha    (cpha),
    .smp_late(smp_late),
    .sdo_en  (sdo_en),
    .sdi     (sdi),
    .busy    (busy_w),
    .sck     (sck),
    .sdo     (sdo),
    .done    (done_w),
    .rx_word (rx_word_w)
  );

  spi_rx_buffer #(.W(DATA_W)) u_rxbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done_w),
    .rx_word (rx_word_w),
    .rd_en   (rd_en),
    .wcol_evt(wcol_evt),
    .rd_data (rd_data),
    .full    (buf_full),
    .irq     (xfer_irq),
    .ovf     (ovf_flag),
    .wcol    (wcol_flag)
  );

  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> (sck == cpol));

  assert_irq_with_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_irq) |-> (buf_full || ovf_flag));

endmodule

// File: tb/spi_shift_master_tb.sv
module spi_shift_master_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, cpol, cpha, smp_late, tmr_tick, sdo_en, sdi;
  logic [7:0] wr_data, rd_data;
  logic [1:0] rate_sel;
  logic       buf_full, xfer_irq, ovf_flag, wcol_flag, sck, sdo;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_shift_master u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .buf_full(buf_full), .xfer_irq(xfer_irq),
    .ovf_flag(ovf_flag), .wcol_flag(wcol_flag), .cpol(cpol), .cpha(cpha),
    .smp_late(smp_late), .rate_sel(rate_sel), .tmr_tick(tmr_tick),
    .sdo_en(sdo_en), .sck(sck), .sdo(sdo), .sdi(sdi)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic read_buf();
    @(negedge clk); rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0;
    check(buf_full, 0, "R10 read clears buffer-full");
  endtask

  // Transfer at clk/4: half-bit period h spans cycles n = 2h, 2h+1 after the write edge.
  task automatic run_pattern(input logic [7:0] tx, input logic [7:0] pa, input logic [7:0] pb,
                             input logic ph, input logic late, input logic en,
                             input logic collide, input logic expect_store,
                             input logic [7:0] exp_rd);
    logic [7:0] got_tx;
    int sck_err, sdo_err, irq_err;
    logic exp_sck, exp_sdo;
    got_tx = '0; sck_err = 0; sdo_err = 0; irq_err = 0;
    cpha = ph; smp_late = late; sdo_en = en; rate_sel = 2'd0;
    @(negedge clk); wr_en = 1'b1; wr_data = tx;
    @(posedge clk);
    for (int n = 0; n < 32; n++) begin
      @(negedge clk);
      wr_en = (collide && n == 10);
      if (collide && n == 10) wr_data = ~tx;
      sdi = ((n / 2) % 2 == 0) ? pa[7 - n / 4] : pb[7 - n / 4];
      exp_sck = cpol ^ (ph ? ((n / 2) % 2 == 1) : ((n / 2) % 2 == 0));
      exp_sdo = en ? tx[7 - n / 4] : 1'b0;
      if (sck !== exp_sck) sck_err++;
      if (sdo !== exp_sdo) sdo_err++;
      if (n % 4 == 1) got_tx[7 - n / 4] = sdo;
      if (xfer_irq !== 1'b0) irq_err++;
      @(posedge clk);
    end
    check(sck_err, 0, "R4 SCK level per half-bit");
    check(sdo_err, 0, en ? "R2 SDO bit timing" : "R8 SDO held low");
    check(got_tx, en ? tx : 8'h00, en ? "R2 MSB-first byte on SDO" : "R8 SDO silent");
    check(irq_err, 0, "R1 no early interrupt");
    @(negedge clk);
    check(xfer_irq, 1, "R1 interrupt after 16 half-bits");
    check(buf_full, 1, "R7 buffer-full at completion");
    check(rd_data, exp_rd, expect_store ? "R5 received byte" : "R10 buffer kept");
    check(sck, cpol, "R3 SCK back to idle");
    @(negedge clk);
    check(xfer_irq, 0, "R1 interrupt one cycle");
  endtask

  task automatic run_duration(input logic [1:0] rs, input int exp_len, input string tag);
    int cyc, ticks;
    cyc = 0; ticks = 0;
    rate_sel = rs; sdi = 1'b1; sdo_en = 1'b1; cpha = 1'b0; smp_late = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h5C;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
    while (!xfer_irq && cyc < 5000) begin
      tmr_tick = (rs == 2'd3) && (cyc % 4 == 3);
      if (tmr_tick) ticks++;
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    tmr_tick = 1'b0;
    check((rs == 2'd3) ? ticks : cyc, exp_len, tag);
    check(rd_data, 8'hFF, "R6 byte received at this rate");
    read_buf();
  endtask

  task automatic t_reset();
    check({sck, sdo, buf_full, xfer_irq, ovf_flag, wcol_flag}, 6'b0, "R11 outputs in reset");
    check(rd_data, 0, "R11 buffer cleared");
  endtask

  task automatic t_idle_polarity();
    @(negedge clk); cpol = 1'b1;
    @(negedge clk); check(sck, 1, "R3 idle high for cpol=1");
    cpol = 1'b0;
    @(negedge clk); check(sck, 0, "R3 idle low for cpol=0");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; wr_data = 0; cpol = 0; cpha = 0;
    smp_late = 0; rate_sel = 0; tmr_tick = 0; sdo_en = 1; sdi = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle_polarity();
    // R5 mid-bit sample, cpha=0
    run_pattern(8'hA5, 8'h3C, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C);
    read_buf();
    // R5 end-of-bit sample, cpha=1, cpol=1 (R3, R4)
    cpol = 1'b1;
    run_pattern(8'h96, 8'h5A, 8'hE1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hE1);
    read_buf();
    cpol = 1'b0;
    // R8 receive-only line monitor
    run_pattern(8'hFF, 8'h81, 8'h7E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81);
    read_buf();
    check(wcol_flag, 0, "R9 no collision yet");
    // R9 write during transfer
    run_pattern(8'h4B, 8'h19, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h19);
    check(wcol_flag, 1, "R9 collision flag set");
    read_buf();
    check(wcol_flag, 1, "R9 collision flag sticky");
    // R6 rates
    run_duration(2'd1, 128, "R6 clk/16 transfer length");
    run_duration(2'd2, 512, "R6 clk/64 transfer length");
    run_duration(2'd3, 16, "R6 timer ticks per transfer");
    // R10 overrun
    check(ovf_flag, 0, "R10 no overrun yet");
    run_pattern(8'h11, 8'h22, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h22);
    run_pattern(8'h33, 8'h44, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h22);
    check(ovf_flag, 1, "R10 overrun flag set");
    read_buf();
    check(rd_data, 8'h22, "R10 old byte still readable");
    check(ovf_flag, 1, "R10 overrun flag sticky");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule